// File: doc/BRIEF.md
# Synthesizer Status Output Multiplexer

This block drives the single status pin of a dual-loop frequency synthesizer that has an IF loop and an RF loop. A 4-bit selection code is built from two 2-bit fields. The upper pair is held in the RF reference latch and the lower pair is held in the IF reference latch. Each latch copy is written only by its own load strobe. The code puts one of several sources on the pin. The sources are constant levels, divider terminal pulses, analog lock indicators for each loop or for both, digital lock flags, and a high-impedance state.

Three of the codes are commands rather than output choices. Each of these raises a counter-reset request for the IF loop, the RF loop, or both. A reset request also tells that loop's charge pump to three-state. The RF latch also carries the charge-pump gain bit. While that bit is set, fastlock mode is active and the pin sinks to ground to switch in a second damping resistor.

Top module: `synth_status_mux`

## Requirements
- R1: While reset is asserted and after it is released with no load strobe, the code is 0000 and fastlock is off. The pin is 0, the output enable is 1, and both reset requests are 0.
- R2: The code is {RF field[1:0], IF field[1:0]}, with the RF field as the upper bits. The RF field and the gain bit are captured only on a clock edge with the RF strobe high. The IF field is captured only on a clock edge with the IF strobe high. Field values presented without their strobe have no effect on the pin.
- R3: Code 0000 drives the pin to 0 and code 0111 drives it to 1.
- R4: Four codes put a divider pulse on the pin: 0010 gives the IF reference divider, 0011 the IF N divider, 1000 the RF reference divider and 1001 the RF N divider.
- R5: Analog lock for a loop is 1 when neither its up pulse nor its down pulse is high. Code 0001 selects IF, code 0100 selects RF, and code 0101 selects the AND of the two.
- R6: Digital lock is selected by three codes: 0110 gives the IF flag, 1100 gives the RF flag, and 1101 gives the AND of the two flags.
- R7: Code 1010 deasserts the output enable. Every other code asserts it.
- R8: Code 1011 raises the IF reset request, 1110 raises the RF request, and 1111 raises both. While a request is raised the pin is 0. No other code raises either request.
- R9: With the gain bit latched at 1, the pin is 0 and the output enable is 1 for every code. Reset requests still follow the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rf_ld | input | 1 | RF reference latch load strobe |
| rf_fld | input | 2 | Upper code bits for the RF latch |
| rf_gain | input | 1 | RF charge-pump gain bit (fastlock) |
| if_ld | input | 1 | IF reference latch load strobe |
| if_fld | input | 2 | Lower code bits for the IF latch |
| if_up | input | 1 | IF phase detector up pulse |
| if_dn | input | 1 | IF phase detector down pulse |
| rf_up | input | 1 | RF phase detector up pulse |
| rf_dn | input | 1 | RF phase detector down pulse |
| if_ref_tick | input | 1 | IF reference divider terminal pulse |
| if_n_tick | input | 1 | IF N divider terminal pulse |
| rf_ref_tick | input | 1 | RF reference divider terminal pulse |
| rf_n_tick | input | 1 | RF N divider terminal pulse |
| if_dlock | input | 1 | IF digital lock flag |
| rf_dlock | input | 1 | RF digital lock flag |
| status_pin | output | 1 | Status pin value |
| status_oe | output | 1 | Status pin output enable |
| if_cnt_rst | output | 1 | IF counter reset and charge-pump three-state request |
| rf_cnt_rst | output | 1 | RF counter reset and charge-pump three-state request |

## Verification
On every cycle the assertions check several properties. Latch copies hold when their strobe is low. The pin is low and enabled under fastlock. The pin is low whenever a reset request is raised. The high-impedance code disables the output. The combined analog lock reports high only when all four phase pulses are quiet.

Some behaviours can only be shown by the bench's scenarios. The bench sweeps every code, with and without fastlock, against all 1024 input patterns. It also checks that the RF and IF fields go to the correct halves of the code, and that unstrobed field changes leave the pin unchanged.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

  localparam int unsigned SSM_FIELD_W = 2;
  localparam int unsigned SSM_CODE_W  = 2 * SSM_FIELD_W;
  localparam int unsigned SSM_LOOPS   = 2;
  localparam int unsigned SSM_IF      = 0;
  localparam int unsigned SSM_RF      = 1;

  typedef enum logic [SSM_CODE_W-1:0] {
    MX_LOW        = 4'b0000,
    MX_IF_ALOCK   = 4'b0001,
    MX_IF_REF     = 4'b0010,
    MX_IF_NDIV    = 4'b0011,
    MX_RF_ALOCK   = 4'b0100,
    MX_BOTH_ALOCK = 4'b0101,
    MX_IF_DLOCK   = 4'b0110,
    MX_HIGH       = 4'b0111,
    MX_RF_REF     = 4'b1000,
    MX_RF_NDIV    = 4'b1001,
    MX_HIZ        = 4'b1010,
    MX_IF_RST     = 4'b1011,
    MX_RF_DLOCK   = 4'b1100,
    MX_BOTH_DLOCK = 4'b1101,
    MX_RF_RST     = 4'b1110,
    MX_BOTH_RST   = 4'b1111
  } mux_code_e;

endpackage

// File: rtl/ssm_sel_latch.sv
module ssm_sel_latch #(
  parameter int unsigned FIELD_W = 2,
  localparam int unsigned CODE_W = 2 * FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rf_ld,
  input  logic [FIELD_W-1:0] rf_fld,
  input  logic               rf_gain,
  input  logic               if_ld,
  input  logic [FIELD_W-1:0] if_fld,
  output logic [CODE_W-1:0]  code,
  output logic               fastlock
);

  logic [FIELD_W-1:0] hi_q, hi_d;
  logic [FIELD_W-1:0] lo_q, lo_d;
  logic               gain_q, gain_d;

  always_comb begin
    hi_d   = hi_q;
    lo_d   = lo_q;
    gain_d = gain_q;
    if (rf_ld) begin
      hi_d   = rf_fld;
      gain_d = rf_gain;
    end
    if (if_ld) begin
      lo_d = if_fld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      gain_q <= 1'b0;
    end else begin
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      gain_q <= gain_d;
    end
  end

  assign code     = {hi_q, lo_q};
  assign fastlock = gain_q;

  AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rf_ld |=> $stable(code[CODE_W-1:FIELD_W])) else $error("upper code bits moved"); // R2
  AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !if_ld |=> $stable(code[FIELD_W-1:0])) else $error("lower code bits moved"); // R2
  AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rf_ld |=> $stable(fastlock)) else $error("gain bit moved"); // R9

endmodule

// File: rtl/ssm_lock_ind.sv
module ssm_lock_ind #(
  parameter int unsigned LOOPS = 2
) (
  input  logic [LOOPS-1:0] up,
  input  logic [LOOPS-1:0] dn,
  output logic [LOOPS-1:0] alock,
  output logic             alock_all
);

  for (genvar g = 0; g < LOOPS; g++) begin : g_loop
    assign alock[g] = ~(up[g] | dn[g]);
  end

  assign alock_all = &alock;

endmodule

// File: rtl/ssm_pin_mux.sv
module ssm_pin_mux
  import ssm_pkg::*;
#(
  parameter int unsigned LOOPS = SSM_LOOPS
) (
  input  logic [SSM_CODE_W-1:0] code,
  input  logic                  fastlock,
  input  logic [LOOPS-1:0]      alock,
  input  logic                  alock_all,
  input  logic [LOOPS-1:0]      ref_tick,
  input  logic [LOOPS-1:0]      n_tick,
  input  logic [LOOPS-1:0]      dlock,
  output logic                  pin,
  output logic                  oe,
  output logic [LOOPS-1:0]      cnt_rst
);

  mux_code_e sel;
  logic      sel_pin;
  logic      sel_oe;

  assign sel = mux_code_e'(code);

  always_comb begin
    sel_pin = 1'b0;
    sel_oe  = 1'b1;
    cnt_rst = '0;
    unique case (sel)
      MX_LOW:        sel_pin = 1'b0;
      MX_IF_ALOCK:   sel_pin = alock[SSM_IF];
      MX_IF_REF:     sel_pin = ref_tick[SSM_IF];
      MX_IF_NDIV:    sel_pin = n_tick[SSM_IF];
      MX_RF_ALOCK:   sel_pin = alock[SSM_RF];
      MX_BOTH_ALOCK: sel_pin = alock_all;
      MX_IF_DLOCK:   sel_pin = dlock[SSM_IF];
      MX_HIGH:       sel_pin = 1'b1;
      MX_RF_REF:     sel_pin = ref_tick[SSM_RF];
      MX_RF_NDIV:    sel_pin = n_tick[SSM_RF];
      MX_HIZ:        sel_oe  = 1'b0;
      MX_IF_RST:     cnt_rst[SSM_IF] = 1'b1;
      MX_RF_DLOCK:   sel_pin = dlock[SSM_RF];
      MX_BOTH_DLOCK: sel_pin = &dlock;
      MX_RF_RST:     cnt_rst[SSM_RF] = 1'b1;
      MX_BOTH_RST:   cnt_rst = '1;
      default:       sel_pin = 1'b0;
    endcase
  end

  // Fastlock sinks the pin to ground to switch the damping resistor.
  assign pin = fastlock ? 1'b0 : sel_pin;
  assign oe  = fastlock ? 1'b1 : sel_oe;

endmodule

// File: rtl/synth_status_mux.sv
module synth_status_mux
  import ssm_pkg::*;
#(
  parameter int unsigned FIELD_W = SSM_FIELD_W,
  localparam int unsigned CODE_W = 2 * FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rf_ld,
  input  logic [FIELD_W-1:0] rf_fld,
  input  logic               rf_gain,
  input  logic               if_ld,
  input  logic [FIELD_W-1:0] if_fld,
  input  logic               if_up,
  input  logic               if_dn,
  input  logic               rf_up,
  input  logic               rf_dn,
  input  logic               if_ref_tick,
  input  logic               if_n_tick,
  input  logic               rf_ref_tick,
  input  logic               rf_n_tick,
  input  logic               if_dlock,
  input  logic               rf_dlock,
  output logic               status_pin,
  output logic               status_oe,
  output logic               if_cnt_rst,
  output logic               rf_cnt_rst
);

  logic [CODE_W-1:0]    code;
  logic                 fastlock;
  logic [SSM_LOOPS-1:0] alock;
  logic                 alock_all;
  logic [SSM_LOOPS-1:0] cnt_rst;

  ssm_sel_latch #(.FIELD_W(FIELD_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .rf_ld    (rf_ld),
    .rf_fld   (rf_fld),
    .rf_gain  (rf_gain),
    .if_ld    (if_ld),
    .if_fld   (if_fld),
    .code     (code),
    .fastlock (fastlock)
  );

  ssm_lock_ind #(.LOOPS(SSM_LOOPS)) u_lock (
    .up        ({rf_up, if_up}),
    .dn        ({rf_dn, if_dn}),
    .alock     (alock),
    .alock_all (alock_all)
  );

  ssm_pin_mux #(.LOOPS(SSM_LOOPS)) u_mux (
    .code      (code),
    .fastlock  (fastlock),
    .alock     (alock),
    .alock_all (alock_all),
    .ref_tick  ({rf_ref_tick, if_ref_tick}),
    .n_tick    ({rf_n_tick, if_n_tick}),
    .dlock     ({rf_dlock, if_dlock}),
    .pin       (status_pin),
    .oe        (status_oe),
    .cnt_rst   (cnt_rst)
  );

  assign if_cnt_rst = cnt_rst[SSM_IF];
  assign rf_cnt_rst = cnt_rst[SSM_RF];

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> (!status_pin && status_oe && !if_cnt_rst && !rf_cnt_rst)) else $error("reset state"); // R1
  AST_FASTLOCK_SINK: assert property (@(posedge clk) disable iff (!rst_n)
    fastlock |-> (!status_pin && status_oe)) else $error("fastlock pin"); // R9
  AST_RST_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (if_cnt_rst || rf_cnt_rst) |-> !status_pin) else $error("pin high during reset request"); // R8
  AST_HIZ_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (code == MX_HIZ && !fastlock) |-> !status_oe) else $error("hiz enabled"); // R7
  AST_BOTH_ALOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (code == MX_BOTH_ALOCK && status_pin) |-> !(if_up || if_dn || rf_up || rf_dn))
    else $error("combined lock with pulses"); // R5
  AST_LOW_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (code == MX_LOW) |-> !status_pin) else $error("low code drove high"); // R3

endmodule

// File: tb/sim_synth_status_mux.sv
module sim_synth_status_mux;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rf_ld, rf_gain, if_ld;
  logic [1:0] rf_fld, if_fld;
  logic [9:0] vec;
  logic       status_pin, status_oe, if_cnt_rst, rf_cnt_rst;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_status_mux u0 (
    .clk(clk), .rst_n(rst_n),
    .rf_ld(rf_ld), .rf_fld(rf_fld), .rf_gain(rf_gain),
    .if_ld(if_ld), .if_fld(if_fld),
    .if_up(vec[0]), .if_dn(vec[1]), .rf_up(vec[2]), .rf_dn(vec[3]),
    .if_ref_tick(vec[4]), .if_n_tick(vec[5]),
    .rf_ref_tick(vec[6]), .rf_n_tick(vec[7]),
    .if_dlock(vec[8]), .rf_dlock(vec[9]),
    .status_pin(status_pin), .status_oe(status_oe),
    .if_cnt_rst(if_cnt_rst), .rf_cnt_rst(rf_cnt_rst)
  );

  // Expected {pin, oe, if_rst, rf_rst}
  function automatic logic [3:0] model(input logic [3:0] c, input logic fl, input logic [9:0] v);
    logic p, o, ir, rr, la_if, la_rf;
    la_if = !(v[0] || v[1]);
    la_rf = !(v[2] || v[3]);
    p = 1'b0; o = 1'b1;
    ir = (c == 4'd11) || (c == 4'd15);
    rr = (c == 4'd14) || (c == 4'd15);
    case (c)
      4'd1:  p = la_if;
      4'd2:  p = v[4];
      4'd3:  p = v[5];
      4'd4:  p = la_rf;
      4'd5:  p = la_if && la_rf;
      4'd6:  p = v[8];
      4'd7:  p = 1'b1;
      4'd8:  p = v[6];
      4'd9:  p = v[7];
      4'd10: o = 1'b0;
      4'd12: p = v[9];
      4'd13: p = v[8] && v[9];
      default: p = 1'b0;
    endcase
    if (fl) begin p = 1'b0; o = 1'b1; end
    return {p, o, ir, rr};
  endfunction

  task automatic check(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {status_pin, status_oe, if_cnt_rst, rf_cnt_rst};
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b (pin,oe,ifrst,rfrst) vec=%b", req, act, exp, vec);
    end
  endtask

  task automatic load(input logic do_rf, input logic [1:0] hi, input logic g,
                      input logic do_if, input logic [1:0] lo);
    @(negedge clk);
    rf_ld = do_rf; rf_fld = hi; rf_gain = g;
    if_ld = do_if; if_fld = lo;
    @(negedge clk);
    rf_ld = 1'b0; if_ld = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; rf_ld = 1'b0; if_ld = 1'b0;
    rf_fld = 2'b11; if_fld = 2'b11; rf_gain = 1'b1; vec = '1;
    // R1: strobes during reset are ignored
    @(negedge clk); rf_ld = 1'b1; if_ld = 1'b1;
    @(negedge clk); #1;
    check("R1 in reset", 4'b0100);
    rf_ld = 1'b0; if_ld = 1'b0; vec = '0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk); #1;
    check("R1 after release", 4'b0100);

    // R3 R4 R5 R6 R7 R8 R9: sweep all codes, gain off and on, all input patterns
    for (int fl = 0; fl < 2; fl++) begin
      for (int c = 0; c < 16; c++) begin
        load(1'b1, 2'(c >> 2), 1'(fl), 1'b1, 2'(c));
        for (int v = 0; v < 1024; v++) begin
          vec = 10'(v);
          #1;
          case (c)
            0, 7:          check(fl ? "R9 fixed" : "R3 fixed", model(4'(c), 1'(fl), vec));
            2, 3, 8, 9:    check(fl ? "R9 divider" : "R4 divider", model(4'(c), 1'(fl), vec));
            1, 4, 5:       check(fl ? "R9 alock" : "R5 alock", model(4'(c), 1'(fl), vec));
            6, 12, 13:     check(fl ? "R9 dlock" : "R6 dlock", model(4'(c), 1'(fl), vec));
            10:            check(fl ? "R9 hiz" : "R7 hiz", model(4'(c), 1'(fl), vec));
            default:       check(fl ? "R9 reset" : "R8 reset", model(4'(c), 1'(fl), vec));
          endcase
        end
      end
    end

    // R2: field ordering and strobe gating
    vec = '0;
    load(1'b1, 2'b01, 1'b0, 1'b1, 2'b11);          // code 0111 -> pin high
    #1; check("R2 load 0111", 4'b1100);
    load(1'b0, 2'b00, 1'b1, 1'b0, 2'b00);          // no strobes
    @(negedge clk); #1;
    check("R2 unstrobed fields ignored", 4'b1100);
    load(1'b0, 2'b10, 1'b1, 1'b1, 2'b00);          // IF only -> code 0100 (RF alock)
    #1; check("R2 IF strobe lower bits, rf quiet", 4'b1100);
    vec[2] = 1'b1; #1;
    check("R2 IF strobe lower bits, rf up", 4'b0100);
    vec[0] = 1'b1; vec[2] = 1'b0; #1;
    check("R2 IF pulse does not affect RF lock", 4'b1100);
    vec = '0;
    load(1'b1, 2'b10, 1'b0, 1'b0, 2'b11);          // RF only -> code 1000 (RF ref)
    vec[6] = 1'b1; #1;
    check("R2 RF strobe upper bits, tick", 4'b1100);
    vec[6] = 1'b0; vec[4] = 1'b1; #1;
    check("R2 RF strobe upper bits, if tick", 4'b0100);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule